// File: doc/BRIEF.md
# Dual-Clock FIFO with Mailbox Registers

This block carries 36-bit words one way, from a port A clock domain to a port B clock domain, through a 64-entry first-in first-out store. Each port has its own free-running clock, and the two clocks may be unrelated or the same. Each side also has a single 36-bit mailbox that the other side can read, so small messages can pass in both directions without going through the queue. Each mailbox has a mail-present flag on the reading side.

Each port is driven by a processor-style control set: an active-low select, an enable, a direction bit and a mailbox steer bit. Port A has a full flag and an almost-full flag, both in its own clock domain. Port B has an empty flag and an almost-empty flag, both in its own clock domain. The write-side data in and read-side data out behave as a stream with back-pressure. A write is accepted only while `a_full` is low, and is silently dropped otherwise. A read returns a word only while `b_empty` is low, and otherwise leaves `b_dout` unchanged. The producer must therefore treat `!a_full` as its ready signal, and the consumer must treat `!b_empty` as its valid signal.

The almost-flag margin is chosen while reset is held low. A two-bit select picks one of four margins, and both clocks must run during reset so that the margin is captured.

Top module: `xclk_fifo_mbx`

## Requirements
- R1: While `rst_n` is low and after it is released with no traffic, `b_empty`=1, `b_aempty`=1, `a_full`=0, `a_afull`=0, `a_mbf`=0 and `b_mbf`=0.
- R2: A port A queue write is a rising `a_clk` edge with `a_cs_n`=0, `a_en`=1, `a_dir`=1 and `a_mbx`=0. A port B queue read is a rising `b_clk` edge with `b_cs_n`=0, `b_en`=1, `b_dir`=1 and `b_mbx`=0. Words leave in the order they entered, each on `b_dout` right after its read edge. This holds when a write and a read share one edge.
- R3: `a_full` rises on the edge of the 64th unread write. A write while `a_full`=1 is dropped and corrupts no stored word.
- R4: A read while `b_empty`=1 leaves `b_dout` unchanged and consumes nothing.
- R5: After a write edge with the clocks coincident, `b_empty` stays high after the first and second following `b_clk` edges and falls only after the third. The write edge itself counts as the first of these three edges.
- R6: A margin M = 4 << `fs_sel` is sampled while `rst_n` is low, so the codes 0,1,2,3 give 4,8,16,32. `a_afull` is high when the stored count seen by port A is at least 64-M.
- R7: `b_aempty` is high when the stored count seen by port B is at most M.
- R8: No queue or mailbox access happens on a port unless its select is 0 and its enable is 1 on the same edge.
- R9: A port A access with `a_mbx`=1 and `a_dir`=1 writes the A-to-B mailbox. `b_mbf` rises after the second `b_clk` edge following the write. A port B access with `b_mbx`=1 and `b_dir`=1 puts the mailbox word on `b_dout` and clears `b_mbf` after that edge. Mailbox traffic leaves the queue and its flags untouched.
- R10: A port B access with `b_mbx`=1 and `b_dir`=0 writes the B-to-A mailbox. `a_mbf` rises after the second following `a_clk` edge. A port A access with `a_mbx`=1 and `a_dir`=0 puts the mailbox word on `a_dout` and clears `a_mbf`.
- R11: A mailbox write is dropped while the previous word in that mailbox has not yet been read, as seen in the writer's domain.
- R12: Reading a mailbox whose flag is low returns the word it holds and leaves the flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset for both domains |
| fs_sel | input | 2 | Almost-flag margin code, sampled during reset |
| a_clk | input | 1 | Port A clock |
| a_cs_n | input | 1 | Port A select, active low |
| a_dir | input | 1 | Port A direction, 1 = write |
| a_en | input | 1 | Port A enable |
| a_mbx | input | 1 | Port A steer to mailbox |
| a_din | input | 36 | Port A write data |
| a_dout | output | 36 | Port A mailbox read data |
| a_full | output | 1 | Queue full, `a_clk` domain |
| a_afull | output | 1 | Queue almost full, `a_clk` domain |
| a_mbf | output | 1 | Mail waiting for port A |
| b_clk | input | 1 | Port B clock |
| b_cs_n | input | 1 | Port B select, active low |
| b_dir | input | 1 | Port B direction, 1 = read |
| b_en | input | 1 | Port B enable |
| b_mbx | input | 1 | Port B steer to mailbox |
| b_din | input | 36 | Port B mailbox write data |
| b_dout | output | 36 | Port B read data |
| b_empty | output | 1 | Queue empty, `b_clk` domain |
| b_aempty | output | 1 | Queue almost empty, `b_clk` domain |
| b_mbf | output | 1 | Mail waiting for port B |

## Verification
The queue path is exercised with several word patterns: all-zero, all-one, alternating, single-bit and mixed. These patterns tell a swapped, stuck or shifted data bit apart from a correct path. A write and a read on one shared edge show whether the two pointers move independently. A fill to 64 words, followed by a rejected extra write and a full drain of ascending values, separates a correct full gate from one that overwrites the oldest word. The mailbox sequences check the two-edge flag latency, the dropping of a second unread write, and a read while the flag is low. Together they distinguish a proper handshake from a flag that simply follows each write.

// File: rtl/xfm_pkg.sv
package xfm_pkg;

  // One decoded access on a port for the current edge.
  typedef struct packed {
    logic fifo;   // queue access (write on A, read on B)
    logic mb_wr;  // mailbox write
    logic mb_rd;  // mailbox read
  } port_req_t;

  // wr_level: the direction value that means "write" on this port.
  function automatic port_req_t port_decode(input logic cs_n,
                                            input logic en,
                                            input logic dir,
                                            input logic mbx,
                                            input logic wr_level);
    port_req_t r;
    logic      act;
    act     = !cs_n && en;
    r.fifo  = act && !mbx && dir;
    r.mb_wr = act && mbx && (dir == wr_level);
    r.mb_rd = act && mbx && (dir != wr_level);
    return r;
  endfunction

endpackage

// File: rtl/xfm_sync2.sv
module xfm_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/xfm_mailbox.sv
module xfm_mailbox #(
  parameter int W = 36
) (
  input  logic         rst_n,
  input  logic         wclk,
  input  logic         wr_req,
  input  logic [W-1:0] wdata,
  input  logic         rclk,
  input  logic         rd_req,
  output logic [W-1:0] rdata,
  output logic         rflag
);
  logic [W-1:0] box_q;
  logic         wtog_q, rtog_q;
  logic         wtog_rs, rtog_ws;
  logic         pend_w;

  // Writer toggle seen by the reader, reader toggle seen by the writer.
  xfm_sync2 #(.W(1)) u_to_rd (.clk(rclk), .rst_n(rst_n), .d(wtog_q), .q(wtog_rs));
  xfm_sync2 #(.W(1)) u_to_wr (.clk(wclk), .rst_n(rst_n), .d(rtog_q), .q(rtog_ws));

  // Mail still unread as far as the writer can tell.
  assign pend_w = wtog_q ^ rtog_ws;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wtog_q <= 1'b0;
      box_q  <= '0;
    end else if (wr_req && !pend_w) begin
      wtog_q <= ~wtog_q;
      box_q  <= wdata;
    end
  end

  assign rflag = wtog_rs ^ rtog_q;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)                rtog_q <= 1'b0;
    else if (rd_req && rflag)  rtog_q <= ~rtog_q;
  end

  // Stable whenever rflag is seen high: the writer is locked out until consumed.
  assign rdata = box_q;
endmodule

// File: rtl/xfm_core.sv
module xfm_core #(
  parameter int W  = 36,
  parameter int AW = 6
) (
  input  logic          rst_n,
  // write domain
  input  logic          wclk,
  input  logic          wr_req,
  input  logic [W-1:0]  wdata,
  input  logic [AW:0]   ofs_w,
  output logic          full,
  output logic          afull,
  // read domain
  input  logic          rclk,
  input  logic          rd_req,
  input  logic [AW:0]   ofs_r,
  output logic          rd_fire,
  output logic [W-1:0]  rd_word,
  output logic          empty,
  output logic          aempty
);
  localparam int             DEPTH   = 1 << AW;
  localparam int             PW      = AW + 1;
  localparam logic [PW-1:0]  DEPTH_P = PW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
  logic [PW-1:0] wbin_nx, rbin_nx;
  logic [PW-1:0] rgray_ws, wgray_rs, rbin_ws, wbin_rs;
  logic [PW-1:0] cnt_w, cnt_r;
  logic          wr_fire;

  // ---- write side ----
  assign wr_fire = wr_req && !full;
  assign wbin_nx = wbin_q + PW'(1);

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (wr_fire) begin
      wbin_q  <= wbin_nx;
      wgray_q <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_fire) mem[wbin_q[AW-1:0]] <= wdata;
  end

  // ---- read side ----
  assign rd_fire = rd_req && !empty;
  assign rbin_nx = rbin_q + PW'(1);

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (rd_fire) begin
      rbin_q  <= rbin_nx;
      rgray_q <= rbin_nx ^ (rbin_nx >> 1);
    end
  end

  assign rd_word = mem[rbin_q[AW-1:0]];

  // ---- crossings ----
  xfm_sync2 #(.W(PW)) u_rptr_to_w (.clk(wclk), .rst_n(rst_n), .d(rgray_q), .q(rgray_ws));
  xfm_sync2 #(.W(PW)) u_wptr_to_r (.clk(rclk), .rst_n(rst_n), .d(wgray_q), .q(wgray_rs));

  for (genvar i = 0; i < PW; i++) begin : g_g2b
    assign rbin_ws[i] = ^rgray_ws[PW-1:i];
    assign wbin_rs[i] = ^wgray_rs[PW-1:i];
  end

  // ---- flags ----
  assign cnt_w  = wbin_q - rbin_ws;
  assign full   = (cnt_w == DEPTH_P);
  assign afull  = (cnt_w >= (DEPTH_P - ofs_w));

  assign cnt_r  = wbin_rs - rbin_q;
  assign empty  = (cnt_r == '0);
  assign aempty = (cnt_r <= ofs_r);
endmodule

// File: rtl/xclk_fifo_mbx.sv
module xclk_fifo_mbx
  import xfm_pkg::*;
#(
  parameter int DW       = 36,
  parameter int AW       = 6,
  parameter int OFS_BASE = 4
) (
  input  logic          rst_n,
  input  logic [1:0]    fs_sel,
  input  logic          a_clk,
  input  logic          a_cs_n,
  input  logic          a_dir,
  input  logic          a_en,
  input  logic          a_mbx,
  input  logic [DW-1:0] a_din,
  output logic [DW-1:0] a_dout,
  output logic          a_full,
  output logic          a_afull,
  output logic          a_mbf,
  input  logic          b_clk,
  input  logic          b_cs_n,
  input  logic          b_dir,
  input  logic          b_en,
  input  logic          b_mbx,
  input  logic [DW-1:0] b_din,
  output logic [DW-1:0] b_dout,
  output logic          b_empty,
  output logic          b_aempty,
  output logic          b_mbf
);
  localparam int PW = AW + 1;

  port_req_t     req_a, req_b;
  logic [PW-1:0] ofs_a_q, ofs_b_q, ofs_sel;
  logic          b_fire;
  logic [DW-1:0] q_word, mb_ab_word, mb_ba_word;

  assign req_a = port_decode(a_cs_n, a_en, a_dir, a_mbx, 1'b1);
  assign req_b = port_decode(b_cs_n, b_en, b_dir, b_mbx, 1'b0);

  // Margin is captured on each clock while reset is held.
  assign ofs_sel = PW'(OFS_BASE) << fs_sel;

  always_ff @(posedge a_clk) begin
    if (!rst_n) ofs_a_q <= ofs_sel;
  end

  always_ff @(posedge b_clk) begin
    if (!rst_n) ofs_b_q <= ofs_sel;
  end

  xfm_core #(.W(DW), .AW(AW)) u_core (
    .rst_n   (rst_n),
    .wclk    (a_clk),
    .wr_req  (req_a.fifo),
    .wdata   (a_din),
    .ofs_w   (ofs_a_q),
    .full    (a_full),
    .afull   (a_afull),
    .rclk    (b_clk),
    .rd_req  (req_b.fifo),
    .ofs_r   (ofs_b_q),
    .rd_fire (b_fire),
    .rd_word (q_word),
    .empty   (b_empty),
    .aempty  (b_aempty)
  );

  xfm_mailbox #(.W(DW)) u_mb_ab (
    .rst_n  (rst_n),
    .wclk   (a_clk),
    .wr_req (req_a.mb_wr),
    .wdata  (a_din),
    .rclk   (b_clk),
    .rd_req (req_b.mb_rd),
    .rdata  (mb_ab_word),
    .rflag  (b_mbf)
  );

  xfm_mailbox #(.W(DW)) u_mb_ba (
    .rst_n  (rst_n),
    .wclk   (b_clk),
    .wr_req (req_b.mb_wr),
    .wdata  (b_din),
    .rclk   (a_clk),
    .rd_req (req_a.mb_rd),
    .rdata  (mb_ba_word),
    .rflag  (a_mbf)
  );

  always_ff @(posedge a_clk or negedge rst_n) begin
    if (!rst_n)            a_dout <= '0;
    else if (req_a.mb_rd)  a_dout <= mb_ba_word;
  end

  always_ff @(posedge b_clk or negedge rst_n) begin
    if (!rst_n)            b_dout <= '0;
    else if (req_b.mb_rd)  b_dout <= mb_ab_word;
    else if (b_fire)       b_dout <= q_word;
  end
endmodule

// File: rtl/xclk_fifo_mbx_chk.sv
module xclk_fifo_mbx_chk #(
  parameter int DW = 36
) (
  input logic          rst_n,
  input logic          a_clk,
  input logic          a_cs_n,
  input logic          a_dir,
  input logic          a_en,
  input logic          a_mbx,
  input logic          a_full,
  input logic          a_afull,
  input logic          a_mbf,
  input logic          b_clk,
  input logic          b_cs_n,
  input logic          b_dir,
  input logic          b_en,
  input logic          b_mbx,
  input logic [DW-1:0] b_dout,
  input logic          b_empty,
  input logic          b_aempty,
  input logic          b_mbf
);
  logic a_wr_try, a_mbrd_try, b_rd_try, b_mbrd_try;

  assign a_wr_try   = !a_cs_n && a_en && a_dir && !a_mbx;
  assign a_mbrd_try = !a_cs_n && a_en && !a_dir && a_mbx;
  assign b_rd_try   = !b_cs_n && b_en && b_dir && !b_mbx;
  assign b_mbrd_try = !b_cs_n && b_en && b_dir && b_mbx;

  p_full_rises_on_write_r3: assert property (@(posedge a_clk) disable iff (!rst_n)
    $rose(a_full) |-> $past(a_wr_try));

  p_empty_rises_on_read_r4: assert property (@(posedge b_clk) disable iff (!rst_n)
    $rose(b_empty) |-> $past(b_rd_try));

  p_no_underflow_r4: assert property (@(posedge b_clk) disable iff (!rst_n)
    (b_empty && b_rd_try) |=> $stable(b_dout));

  p_full_within_afull_r6: assert property (@(posedge a_clk) disable iff (!rst_n)
    a_full |-> a_afull);

  p_empty_within_aempty_r7: assert property (@(posedge b_clk) disable iff (!rst_n)
    b_empty |-> b_aempty);

  p_mbf_b_clears_r9: assert property (@(posedge b_clk) disable iff (!rst_n)
    (b_mbf && b_mbrd_try) |=> !b_mbf);

  p_mbf_a_clears_r10: assert property (@(posedge a_clk) disable iff (!rst_n)
    (a_mbf && a_mbrd_try) |=> !a_mbf);
endmodule

bind xclk_fifo_mbx xclk_fifo_mbx_chk #(.DW(DW)) u_chk (
  .rst_n    (rst_n),
  .a_clk    (a_clk),
  .a_cs_n   (a_cs_n),
  .a_dir    (a_dir),
  .a_en     (a_en),
  .a_mbx    (a_mbx),
  .a_full   (a_full),
  .a_afull  (a_afull),
  .a_mbf    (a_mbf),
  .b_clk    (b_clk),
  .b_cs_n   (b_cs_n),
  .b_dir    (b_dir),
  .b_en     (b_en),
  .b_mbx    (b_mbx),
  .b_dout   (b_dout),
  .b_empty  (b_empty),
  .b_aempty (b_aempty),
  .b_mbf    (b_mbf)
);

// File: tb/xclk_fifo_mbx_tb.sv
`timescale 1ns/1ps
module xclk_fifo_mbx_tb;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    fs_sel;
  logic          a_cs_n, a_dir, a_en, a_mbx;
  logic [DW-1:0] a_din, a_dout;
  logic          a_full, a_afull, a_mbf;
  logic          b_cs_n, b_dir, b_en, b_mbx;
  logic [DW-1:0] b_din, b_dout;
  logic          b_empty, b_aempty, b_mbf;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz, both ports on one clock

  xclk_fifo_mbx u_dut (
    .rst_n(rst_n), .fs_sel(fs_sel),
    .a_clk(clk), .a_cs_n(a_cs_n), .a_dir(a_dir), .a_en(a_en), .a_mbx(a_mbx),
    .a_din(a_din), .a_dout(a_dout), .a_full(a_full), .a_afull(a_afull), .a_mbf(a_mbf),
    .b_clk(clk), .b_cs_n(b_cs_n), .b_dir(b_dir), .b_en(b_en), .b_mbx(b_mbx),
    .b_din(b_din), .b_dout(b_dout), .b_empty(b_empty), .b_aempty(b_aempty), .b_mbf(b_mbf)
  );

  localparam logic [DW-1:0] VEC [9] = '{
    36'h0_0000_0000, 36'hF_FFFF_FFFF, 36'hA_AAAA_AAAA, 36'h5_5555_5555,
    36'h0_0000_0001, 36'h8_0000_0000, 36'h1_2345_6789, 36'hF_0F0F_0F0F,
    36'h0_FFFF_0000
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    a_cs_n = 1'b1; a_en = 1'b0; a_mbx = 1'b0;
    b_cs_n = 1'b1; b_en = 1'b0; b_mbx = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic set_a(input logic cs_n, dir, en, mbx, input logic [DW-1:0] d);
    a_cs_n = cs_n; a_dir = dir; a_en = en; a_mbx = mbx; a_din = d;
  endtask

  task automatic set_b(input logic cs_n, dir, en, mbx, input logic [DW-1:0] d);
    b_cs_n = cs_n; b_dir = dir; b_en = en; b_mbx = mbx; b_din = d;
  endtask

  task automatic a_wr(input logic [DW-1:0] d);
    set_a(1'b0, 1'b1, 1'b1, 1'b0, d); step();
  endtask

  task automatic b_rd();
    set_b(1'b0, 1'b1, 1'b1, 1'b0, '0); step();
  endtask

  task automatic do_reset(input logic [1:0] code);
    fs_sel = code;
    rst_n  = 1'b0;
    idle(4);
    rst_n  = 1'b1;
    idle(1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fs_sel = 2'd1;
    set_a(1'b1, 1'b1, 1'b0, 1'b0, '0);
    set_b(1'b1, 1'b1, 1'b0, 1'b0, '0);
    @(negedge clk);
    do_reset(2'd1);  // margin 8

    // R1 reset state
    chk("R1 b_empty", b_empty, 1);
    chk("R1 b_aempty", b_aempty, 1);
    chk("R1 a_full", a_full, 0);
    chk("R1 a_afull", a_afull, 0);
    chk("R1 a_mbf", a_mbf, 0);
    chk("R1 b_mbf", b_mbf, 0);

    // R5 crossing latency
    a_wr(36'h0_1234_5678);
    chk("R5 empty after write edge", b_empty, 1);
    idle(1);
    chk("R5 empty after edge 2", b_empty, 1);
    idle(1);
    chk("R5 empty clear after edge 3", b_empty, 0);

    // R2 write and read on the same edge
    set_a(1'b0, 1'b1, 1'b1, 1'b0, 36'h9_8765_4321);
    set_b(1'b0, 1'b1, 1'b1, 1'b0, '0);
    step();
    chk("R2 shared-edge read data", b_dout, 36'h0_1234_5678);
    idle(3);
    b_rd();
    chk("R2 shared-edge written word", b_dout, 36'h9_8765_4321);

    // R4 read while empty
    chk("R4 empty before read", b_empty, 1);
    b_rd();
    chk("R4 dout held", b_dout, 36'h9_8765_4321);

    // R2/R7 pattern table
    for (int i = 0; i < 8; i++) a_wr(VEC[i]);
    idle(3);
    chk("R7 aempty at count 8", b_aempty, 1);
    chk("R7 not empty", b_empty, 0);
    a_wr(VEC[8]);
    idle(3);
    chk("R7 aempty clear at count 9", b_aempty, 0);
    for (int i = 0; i < 9; i++) begin
      b_rd();
      chk($sformatf("R2 order word %0d", i), b_dout, VEC[i]);
    end
    chk("R2 empty after drain", b_empty, 1);

    // R8 gating on port A
    set_a(1'b1, 1'b1, 1'b1, 1'b0, 36'h1); step();
    set_a(1'b0, 1'b1, 1'b0, 1'b0, 36'h2); step();
    idle(3);
    chk("R8 gated writes ignored", b_empty, 1);

    // R3/R6 fill
    for (int i = 0; i < 55; i++) a_wr(36'h100 + 36'(i));
    chk("R6 afull clear at 55", a_afull, 0);
    a_wr(36'h100 + 36'd55);
    chk("R6 afull set at 56", a_afull, 1);
    for (int i = 56; i < 63; i++) a_wr(36'h100 + 36'(i));
    chk("R3 not full at 63", a_full, 0);
    a_wr(36'h100 + 36'd63);
    chk("R3 full at 64", a_full, 1);
    a_wr(36'h0_DEAD_BEEF);
    idle(3);
    set_b(1'b1, 1'b1, 1'b1, 1'b0, '0); step();
    chk("R8 gated read ignored", b_dout, VEC[8]);
    for (int i = 0; i < 64; i++) begin
      b_rd();
      chk($sformatf("R3 drain word %0d", i), b_dout, 36'h100 + 36'(i));
    end
    chk("R3 empty after 64", b_empty, 1);
    idle(3);
    chk("R3 full cleared", a_full, 0);

    // R9/R11/R12 mailbox A to B
    set_a(1'b0, 1'b1, 1'b1, 1'b1, 36'h0_AAAA_0001); step();
    chk("R9 mbf after write edge", b_mbf, 0);
    idle(1);
    chk("R9 mbf after edge 2", b_mbf, 0);
    idle(1);
    chk("R9 mbf set", b_mbf, 1);
    chk("R9 queue untouched", b_empty, 1);
    set_a(1'b0, 1'b1, 1'b1, 1'b1, 36'h0_AAAA_0002); step();
    idle(2);
    set_b(1'b0, 1'b1, 1'b1, 1'b1, '0); step();
    chk("R11 second write dropped", b_dout, 36'h0_AAAA_0001);
    chk("R9 mbf cleared by read", b_mbf, 0);
    idle(3);
    chk("R11 no flag from dropped write", b_mbf, 0);
    set_b(1'b0, 1'b1, 1'b1, 1'b1, '0); step();
    chk("R12 flag-low read data", b_dout, 36'h0_AAAA_0001);
    chk("R12 flag stays low", b_mbf, 0);
    set_a(1'b0, 1'b1, 1'b1, 1'b1, 36'h0_AAAA_0003); step();
    idle(2);
    chk("R11 write after consume accepted", b_mbf, 1);
    set_b(1'b0, 1'b1, 1'b1, 1'b1, '0); step();
    chk("R11 new mail data", b_dout, 36'h0_AAAA_0003);

    // R10 mailbox B to A
    set_b(1'b0, 1'b0, 1'b1, 1'b1, 36'h0_BBBB_0004); step();
    chk("R10 a_mbf after write edge", a_mbf, 0);
    idle(2);
    chk("R10 a_mbf set", a_mbf, 1);
    set_a(1'b0, 1'b0, 1'b1, 1'b1, '0); step();
    chk("R10 a_dout", a_dout, 36'h0_BBBB_0004);
    chk("R10 a_mbf cleared", a_mbf, 0);

    // R6/R7 with margin 32
    do_reset(2'd3);
    chk("R1 empty after second reset", b_empty, 1);
    chk("R1 a_mbf after second reset", a_mbf, 0);
    for (int i = 0; i < 31; i++) a_wr(36'(i));
    chk("R6 afull clear at 31 (margin 32)", a_afull, 0);
    a_wr(36'd31);
    chk("R6 afull set at 32 (margin 32)", a_afull, 1);
    idle(3);
    chk("R7 aempty at 32 (margin 32)", b_aempty, 1);
    a_wr(36'd32);
    idle(3);
    chk("R7 aempty clear at 33", b_aempty, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule